// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block carries out one 32-bit data-processing operation for a processor execute stage. The opcode selects one of sixteen operations. The block also receives the set-flags bit, the value and index of the first source register, the instruction address, an already-shifted second operand together with the shifter's carry-out, the destination index, the live NZCV flags and the saved NZCV flags. It does not contain the shifter, the register file, fetch or memory.

From these inputs it computes a result with a write enable, the next flag value with a write enable, and a pipeline-flush request for writes to the program counter. Two cases change the meaning of an instruction. With set-flags clear, the four compare opcodes turn into status-register transfers. With set-flags set and the program counter as destination, the saved flags are restored and the flags from the ALU are discarded. When the first source is the program counter, the block supplies the pipeline-ahead value in its place.

The whole computation is combinational. Its outputs are captured once for each valid strobe, so results appear one cycle after the strobe.

Top module: `dpa_unit`

## Requirements
- R1: Opcode encoding is AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. Flags are ordered {N,Z,C,V} with N at bit 3. For a logical operation (AND, EOR, TST, TEQ, ORR, MOV, BIC, MVN) with set-flags set, N is result bit 31, Z is set when the result is zero, C is the shifter carry-out and V keeps its current value.
- R2: ADD, ADC, SUB, SBC, RSB and RSC produce a+b, a+b+C, a−b, a−b−(1−C), b−a and b−a−(1−C), all modulo 2^32.
- R3: For an arithmetic operation with set-flags set, C is the carry-out for additions and NOT borrow for subtractions, V is signed overflow, and N and Z come from the result.
- R4: TST, TEQ, CMP and CMN with set-flags set update the flags and never assert the result write enable.
- R5: With set-flags clear, the flag write enable is low and flags_next equals the current flags; non-compare operations write their result.
- R6: With set-flags clear, opcodes 8 to 11 raise psr_xfer, write neither the result nor the flags, and put the second operand on result. xfer_kind is {read, saved}: TEQ=00 (write live), CMN=01 (write saved), TST=10 (read live), CMP=11 (read saved).
- R7: When the first source index is the program counter (index 15), the first operand is the instruction address plus 8, or plus 12 when the second operand is shifted by a register amount.
- R8: With set-flags set and destination 15, restore_saved is raised and flags_next is the saved flags, whatever the ALU produced.
- R9: flush is raised exactly when a result is written to destination 15.
- R10: The outputs register once per in_valid strobe with one cycle of latency. out_valid follows in_valid by one cycle, and reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Set-flags bit |
| src_idx | input | 4 | First-source register index |
| src_val | input | 32 | First-source register value |
| insn_addr | input | 32 | Address of the instruction |
| b_reg_shift | input | 1 | Second operand shifted by a register amount |
| op_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Shifter carry-out |
| dst_idx | input | 4 | Destination register index |
| cur_flags | input | 4 | Live NZCV |
| saved_flags | input | 4 | Saved NZCV |
| out_valid | output | 1 | Outputs carry a result |
| result | output | 32 | Result or transfer value |
| result_we | output | 1 | Result write enable |
| dst_out | output | 4 | Destination index |
| flags_next | output | 4 | Next NZCV |
| flags_we | output | 1 | Flag write enable |
| psr_xfer | output | 1 | Status-register transfer |
| xfer_kind | output | 2 | {read, saved} transfer kind |
| restore_saved | output | 1 | Saved status restored into live status |
| flush | output | 1 | Pipeline flush request |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, 4-bit register indices and the program counter at index 15. At these values the bench can drive the 32-bit carry and overflow boundaries, such as all-ones plus one and the largest positive value plus one. It can also drive both pipeline-ahead offsets on the real program-counter index, and destination-15 cases where restore and flush interact with the compare opcodes.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // compare group: flags only, never a result write
  function automatic logic op_is_test(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic op_is_logical(alu_op_e op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // operands swapped before the adder
  function automatic logic op_swaps(alu_op_e op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

  // second adder input inverted (subtract forms)
  function automatic logic op_inverts(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // carry into the adder
  function automatic logic op_carry_in(alu_op_e op, logic c_flag);
    case (op)
      OP_SUB, OP_RSB, OP_CMP:   return 1'b1;
      OP_ADC, OP_SBC, OP_RSC:   return c_flag;
      default:                  return 1'b0;
    endcase
  endfunction

  // transfer kind {read, saved} for the compare group with set-flags clear
  function automatic logic [1:0] xfer_code(alu_op_e op);
    case (op)
      OP_TEQ:  return 2'b00;
      OP_CMN:  return 2'b01;
      OP_TST:  return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/dpa_opsel.sv
module dpa_opsel #(
  parameter int XLEN      = 32,
  parameter int RIDX_W    = 4,
  parameter int PC_IDX    = 15,
  parameter int PC_AHEAD  = 8,
  parameter int RS_EXTRA  = 4
) (
  input  logic [RIDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   insn_addr,
  input  logic              b_reg_shift,
  output logic              src_is_pc,
  output logic [XLEN-1:0]   op_a
);
  localparam logic [RIDX_W-1:0] PC_CODE   = RIDX_W'(PC_IDX);
  localparam logic [XLEN-1:0]   AHEAD_N   = XLEN'(PC_AHEAD);
  localparam logic [XLEN-1:0]   AHEAD_RS  = XLEN'(PC_AHEAD + RS_EXTRA);

  assign src_is_pc = (src_idx == PC_CODE);

  always_comb begin
    if (!src_is_pc)       op_a = src_val;
    else if (b_reg_shift) op_a = insn_addr + AHEAD_RS;
    else                  op_a = insn_addr + AHEAD_N;
  end
endmodule

// File: rtl/dpa_arith.sv
module dpa_arith
  import dpa_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            c_flag,
  output logic [XLEN-1:0] sum,
  output logic            carry,
  output logic            ovf
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] p, q, q_in;
  logic            cin;

  always_comb begin
    p    = op_swaps(op) ? b : a;
    q    = op_swaps(op) ? a : b;
    q_in = op_inverts(op) ? ~q : q;
    cin  = op_carry_in(op, c_flag);
    {carry, sum} = {1'b0, p} + {1'b0, q_in} + {{XLEN{1'b0}}, cin};
    ovf  = (p[MSB] == q_in[MSB]) && (sum[MSB] != p[MSB]);
  end
endmodule

// File: rtl/dpa_logic.sv
module dpa_logic
  import dpa_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dpa_unit.sv
module dpa_unit
  import dpa_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic              set_flags,
  input  logic [RIDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   insn_addr,
  input  logic              b_reg_shift,
  input  logic [XLEN-1:0]   op_b,
  input  logic              shift_carry,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [3:0]        cur_flags,
  input  logic [3:0]        saved_flags,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic              result_we,
  output logic [RIDX_W-1:0] dst_out,
  output logic [3:0]        flags_next,
  output logic              flags_we,
  output logic              psr_xfer,
  output logic [1:0]        xfer_kind,
  output logic              restore_saved,
  output logic              flush
);
  localparam int                MSB     = XLEN - 1;
  localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

  alu_op_e op;
  nzcv_t   cur_f;
  assign op    = alu_op_e'(op_code);
  assign cur_f = nzcv_t'(cur_flags);

  // named internal events
  logic            src_is_pc;
  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] arith_sum, logic_res, alu_res;
  logic            arith_c, arith_v;
  logic            ev_test, ev_logical, ev_xfer, ev_dst_pc, ev_restore;
  logic            ev_write, ev_flush;
  nzcv_t           alu_f, next_f;

  dpa_opsel #(.XLEN(XLEN), .RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_opsel (
    .src_idx     (src_idx),
    .src_val     (src_val),
    .insn_addr   (insn_addr),
    .b_reg_shift (b_reg_shift),
    .src_is_pc   (src_is_pc),
    .op_a        (op_a)
  );

  dpa_arith #(.XLEN(XLEN)) u_arith (
    .op     (op),
    .a      (op_a),
    .b      (op_b),
    .c_flag (cur_f.c),
    .sum    (arith_sum),
    .carry  (arith_c),
    .ovf    (arith_v)
  );

  dpa_logic #(.XLEN(XLEN)) u_logic (
    .op  (op),
    .a   (op_a),
    .b   (op_b),
    .res (logic_res)
  );

  assign ev_test    = op_is_test(op);
  assign ev_logical = op_is_logical(op);
  assign ev_xfer    = ev_test && !set_flags;
  assign ev_dst_pc  = (dst_idx == PC_CODE);
  assign ev_restore = set_flags && ev_dst_pc;
  assign ev_write   = !ev_test;
  assign ev_flush   = ev_write && ev_dst_pc;
  assign alu_res    = ev_logical ? logic_res : arith_sum;

  always_comb begin
    alu_f.n = alu_res[MSB];
    alu_f.z = (alu_res == '0);
    alu_f.c = ev_logical ? shift_carry : arith_c;
    alu_f.v = ev_logical ? cur_f.v : arith_v;
    if (ev_restore)     next_f = nzcv_t'(saved_flags);
    else if (set_flags) next_f = alu_f;
    else                next_f = cur_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      result        <= '0;
      result_we     <= 1'b0;
      dst_out       <= '0;
      flags_next    <= '0;
      flags_we      <= 1'b0;
      psr_xfer      <= 1'b0;
      xfer_kind     <= '0;
      restore_saved <= 1'b0;
      flush         <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result        <= ev_xfer ? op_b : alu_res;
        result_we     <= ev_write;
        dst_out       <= dst_idx;
        flags_next    <= next_f;
        flags_we      <= set_flags;
        psr_xfer      <= ev_xfer;
        xfer_kind     <= ev_xfer ? xfer_code(op) : 2'b00;
        restore_saved <= ev_restore;
        flush         <= ev_flush;
      end
    end
  end
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op_code,
  input logic              set_flags,
  input logic [RIDX_W-1:0] dst_idx,
  input logic [3:0]        saved_flags,
  input logic              out_valid,
  input logic              result_we,
  input logic [RIDX_W-1:0] dst_out,
  input logic [3:0]        flags_next,
  input logic              flags_we,
  input logic              psr_xfer,
  input logic              restore_saved,
  input logic              flush
);
  localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_test_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags && op_code[3:2] == 2'b10) |=> !result_we);

  assert_sclear_no_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !set_flags) |=> (!flags_we && !restore_saved));

  assert_xfer_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && psr_xfer) |-> (!result_we && !flags_we && !flush));

  assert_restore_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_flags && dst_idx == PC_CODE) |=>
      (restore_saved && flags_next == $past(saved_flags)));

  assert_flush_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flush) |-> (result_we && dst_out == PC_CODE));

  assert_flush_missing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result_we && dst_out == PC_CODE) |-> flush);
endmodule

bind dpa_unit dpa_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .op_code       (op_code),
  .set_flags     (set_flags),
  .dst_idx       (dst_idx),
  .saved_flags   (saved_flags),
  .out_valid     (out_valid),
  .result_we     (result_we),
  .dst_out       (dst_out),
  .flags_next    (flags_next),
  .flags_we      (flags_we),
  .psr_xfer      (psr_xfer),
  .restore_saved (restore_saved),
  .flush         (flush)
);

// File: tb/sim_dpa_unit.sv
`timescale 1ns/1ps
module sim_dpa_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  src_idx = '0;
  logic [31:0] src_val = '0;
  logic [31:0] insn_addr = '0;
  logic        b_reg_shift = 1'b0;
  logic [31:0] op_b = '0;
  logic        shift_carry = 1'b0;
  logic [3:0]  dst_idx = '0;
  logic [3:0]  cur_flags = '0;
  logic [3:0]  saved_flags = '0;
  logic        out_valid, result_we, flags_we, psr_xfer, restore_saved, flush;
  logic [31:0] result;
  logic [3:0]  dst_out, flags_next;
  logic [1:0]  xfer_kind;

  always #2.5 clk = ~clk;

  dpa_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .set_flags(set_flags), .src_idx(src_idx), .src_val(src_val),
    .insn_addr(insn_addr), .b_reg_shift(b_reg_shift), .op_b(op_b),
    .shift_carry(shift_carry), .dst_idx(dst_idx), .cur_flags(cur_flags),
    .saved_flags(saved_flags), .out_valid(out_valid), .result(result),
    .result_we(result_we), .dst_out(dst_out), .flags_next(flags_next),
    .flags_we(flags_we), .psr_xfer(psr_xfer), .xfer_kind(xfer_kind),
    .restore_saved(restore_saved), .flush(flush)
  );

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic        chk_res;
    logic        we;
    logic [3:0]  dst;
    logic [3:0]  fl;
    logic        fwe;
    logic        xfer;
    logic [1:0]  kind;
    logic        rest;
    logic        fl_sh;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  int n_sent = 0;
  int n_seen = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input string tag, input logic [3:0] op, input logic s,
      input logic [31:0] av, input logic [3:0] si, input logic [31:0] ia,
      input logic brs, input logic [31:0] b, input logic sc, input logic [3:0] di,
      input logic [3:0] cf, input logic [3:0] sf);
    exp_t e;
    logic [31:0] a, r;
    logic c, v;
    longint full, sfull, x, y, sx, sy;
    bit logical, test, is_sub;
    e.tag = tag;
    a = (si == 4'd15) ? ia + (brs ? 32'd12 : 32'd8) : av;
    test = (op >= 4'd8 && op <= 4'd11);
    logical = (op == 0 || op == 1 || op == 8 || op == 9 || op >= 4'd12);
    c = sc; v = cf[0]; r = '0; is_sub = 0;
    x = 0; y = 0; sx = 0; sy = 0; full = 0; sfull = 0;
    case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      default: ;
    endcase
    if (!logical) begin
      case (op)
        4'd3, 4'd7: begin x = longint'(b); y = longint'(a); end
        default:    begin x = longint'(a); y = longint'(b); end
      endcase
      sx = (x >= 64'sh80000000) ? x - 64'sh100000000 : x;
      sy = (y >= 64'sh80000000) ? y - 64'sh100000000 : y;
      case (op)
        4'd4, 4'd11: begin full = x + y;         sfull = sx + sy; end
        4'd5:        begin full = x + y + cf[1]; sfull = sx + sy + cf[1]; end
        4'd2, 4'd3, 4'd10: begin is_sub = 1; full = x - y; sfull = sx - sy; end
        default: begin is_sub = 1;
          full = x - y - (1 - cf[1]); sfull = sx - sy - (1 - cf[1]); end
      endcase
      r = full[31:0];
      c = is_sub ? (full >= 0) : (full > 64'shFFFFFFFF);
      v = (sfull > 64'sh7FFFFFFF) || (sfull < -64'sh80000000);
    end
    e.xfer  = test && !s;
    e.kind  = !e.xfer ? 2'b00 : (op == 9) ? 2'b00 : (op == 11) ? 2'b01 :
              (op == 8) ? 2'b10 : 2'b11;
    e.we    = !test;
    e.dst   = di;
    e.fwe   = s;
    e.rest  = s && (di == 4'd15);
    e.fl    = e.rest ? sf : s ? {r[31], r == 0, c, v} : cf;
    e.fl_sh = e.we && (di == 4'd15);
    e.res   = e.xfer ? b : r;
    e.chk_res = e.we || e.xfer;
    return e;
  endfunction

  task automatic send(input string tag, input logic [3:0] op, input logic s,
      input logic [31:0] av, input logic [3:0] si, input logic [31:0] ia,
      input logic brs, input logic [31:0] b, input logic sc, input logic [3:0] di,
      input logic [3:0] cf, input logic [3:0] sf);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; set_flags = s; src_val = av; src_idx = si;
    insn_addr = ia; b_reg_shift = brs; op_b = b; shift_carry = sc;
    dst_idx = di; cur_flags = cf; saved_flags = sf;
    q.push_back(model(tag, op, s, av, si, ia, brs, b, sc, di, cf, sf));
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compares each result against the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid === 1'b1) begin
        if (q.size() == 0) chk("R10", "unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          n_seen++;
          if (e.chk_res) chk(e.tag, "result", result, e.res);
          chk(e.tag, "result_we", {31'd0, result_we}, {31'd0, e.we});
          chk(e.tag, "dst_out", {28'd0, dst_out}, {28'd0, e.dst});
          chk(e.tag, "flags_next", {28'd0, flags_next}, {28'd0, e.fl});
          chk(e.tag, "flags_we", {31'd0, flags_we}, {31'd0, e.fwe});
          chk(e.tag, "psr_xfer", {31'd0, psr_xfer}, {31'd0, e.xfer});
          chk(e.tag, "xfer_kind", {30'd0, xfer_kind}, {30'd0, e.kind});
          chk(e.tag, "restore", {31'd0, restore_saved}, {31'd0, e.rest});
          chk(e.tag, "flush", {31'd0, flush}, {31'd0, e.fl_sh});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset out_valid", {31'd0, out_valid}, 0);
    chk("R10", "reset result", result, 0);
    chk("R10", "reset flags", {28'd0, flags_next}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after reset", {31'd0, out_valid}, 0);

    // R1 logical with flags
    send("R1 AND", 4'd0, 1, 32'hF0F0_00FF, 4'd2, 0, 0, 32'h0FF0_0F0F, 1, 4'd3, 4'b0001, 4'b0000);
    send("R1 EOR zero", 4'd1, 1, 32'h1234_5678, 4'd2, 0, 0, 32'h1234_5678, 0, 4'd3, 4'b0010, 4'b0000);
    send("R1 MVN", 4'd15, 1, 32'h0, 4'd2, 0, 0, 32'h0, 1, 4'd4, 4'b0000, 4'b0000);
    send("R1 ORR", 4'd12, 1, 32'h8000_0000, 4'd2, 0, 0, 32'h1, 0, 4'd5, 4'b0111, 4'b0000);
    // R5 flags untouched with S clear
    send("R5 BIC", 4'd14, 0, 32'hFFFF_FFFF, 4'd2, 0, 0, 32'h00FF_00FF, 1, 4'd6, 4'b1010, 4'b0101);
    // R3 carry and overflow boundaries
    send("R3 ADD carry", 4'd4, 1, 32'hFFFF_FFFF, 4'd1, 0, 0, 32'h1, 0, 4'd2, 4'b0000, 4'b0000);
    send("R3 ADD ovf", 4'd4, 1, 32'h7FFF_FFFF, 4'd1, 0, 0, 32'h1, 0, 4'd2, 4'b0000, 4'b0000);
    send("R3 SUB borrow", 4'd2, 1, 32'd5, 4'd1, 0, 0, 32'd7, 0, 4'd2, 4'b0000, 4'b0000);
    send("R3 SUB ovf", 4'd2, 1, 32'h8000_0000, 4'd1, 0, 0, 32'd1, 0, 4'd2, 4'b0000, 4'b0000);
    // R2 arithmetic forms and operand order
    send("R2 SUB", 4'd2, 1, 32'd7, 4'd1, 0, 0, 32'd5, 0, 4'd2, 4'b0000, 4'b0000);
    send("R2 RSB", 4'd3, 0, 32'd3, 4'd1, 0, 0, 32'd10, 0, 4'd2, 4'b0000, 4'b0000);
    send("R2 ADC", 4'd5, 1, 32'd100, 4'd1, 0, 0, 32'd23, 0, 4'd2, 4'b0010, 4'b0000);
    send("R2 SBC", 4'd6, 1, 32'd10, 4'd1, 0, 0, 32'd3, 0, 4'd2, 4'b0000, 4'b0000);
    send("R2 RSC", 4'd7, 0, 32'd4, 4'd1, 0, 0, 32'd20, 0, 4'd2, 4'b0010, 4'b0000);
    send("R2 SBC C1", 4'd6, 1, 32'd0, 4'd1, 0, 0, 32'd0, 0, 4'd2, 4'b0010, 4'b0000);
    // R4 compare group with flags
    send("R4 CMP eq", 4'd10, 1, 32'd9, 4'd1, 0, 0, 32'd9, 0, 4'd2, 4'b0000, 4'b0000);
    send("R4 CMN", 4'd11, 1, 32'hFFFF_FFFF, 4'd1, 0, 0, 32'd1, 0, 4'd2, 4'b0000, 4'b0000);
    send("R4 TST", 4'd8, 1, 32'hF0, 4'd1, 0, 0, 32'h0F, 1, 4'd2, 4'b0001, 4'b0000);
    send("R4 TEQ", 4'd9, 1, 32'h8000_0000, 4'd1, 0, 0, 32'h1, 0, 4'd2, 4'b0000, 4'b0000);
    // R6 status transfers
    send("R6 TEQ", 4'd9, 0, 32'd1, 4'd1, 0, 0, 32'hA000_0013, 0, 4'd2, 4'b0100, 4'b1001);
    send("R6 CMN", 4'd11, 0, 32'd1, 4'd1, 0, 0, 32'h5000_001F, 0, 4'd2, 4'b0100, 4'b1001);
    send("R6 TST", 4'd8, 0, 32'd1, 4'd1, 0, 0, 32'h0000_0010, 0, 4'd7, 4'b0100, 4'b1001);
    send("R6 CMP", 4'd10, 0, 32'd1, 4'd1, 0, 0, 32'h0000_0020, 0, 4'd8, 4'b0100, 4'b1001);
    // R7 program counter as first operand
    send("R7 pc+8", 4'd4, 0, 32'hDEAD_BEEF, 4'd15, 32'h0000_1000, 0, 32'd0, 0, 4'd2, 4'b0000, 4'b0000);
    send("R7 pc+12", 4'd4, 0, 32'hDEAD_BEEF, 4'd15, 32'h0000_1000, 1, 32'd0, 0, 4'd2, 4'b0000, 4'b0000);
    // R8 and R9 destination is the program counter
    send("R8 MOVS pc", 4'd13, 1, 32'd0, 4'd1, 0, 0, 32'h0000_0000, 1, 4'd15, 4'b0000, 4'b1011);
    send("R9 MOV pc", 4'd13, 0, 32'd0, 4'd1, 0, 0, 32'h0000_2000, 0, 4'd15, 4'b0110, 4'b1111);
    send("R8 CMP pc", 4'd10, 1, 32'd1, 4'd1, 0, 0, 32'd1, 0, 4'd15, 4'b0000, 4'b0101);
    idle(4);
    chk("R10", "idle out_valid", {31'd0, out_valid}, 0);
    chk("R10", "all results returned", n_seen, n_sent);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule